// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Controller

This block records a stream of 32-bit logic samples into a circular on-chip buffer while it is armed, and reacts to a one-cycle trigger-start pulse. After the pulse it keeps storing for a programmed number of further samples and then stops. It then plays the captured window back as a byte stream, oldest sample first, through a valid/ready port that feeds a serial transmitter further down the chain.

The samples are divided into four 8-bit channel groups. Groups can be switched off by configuration flags. Only enabled groups are stored, packed densely into four byte-wide RAM lanes. The buffer therefore holds more samples when fewer groups are enabled. A programmable divider sets how often a sample is taken. An internal test mode replaces the input pins with a generated counting pattern.

The window sizes arrive in the 32-bit argument of a capture-size command. Both counts are in units of four samples and are encoded minus one. All configuration is sampled when the block is armed. A clear strobe aborts capture or playback at any time.

Top module: `capture_ctrl`

## Requirements
- R1: `size_arg[15:0]` holds the read count minus one and `size_arg[31:16]` holds the delay count minus one, both in units of four samples, so the requested read length is 4·(size_arg[15:0]+1) samples and the post-trigger length is 4·(size_arg[31:16]+1) samples.
- R2: After a trigger pulse is seen while armed, exactly 4·(delay count) further samples are stored and then storing stops and playback begins. A sample taken in the same cycle as the trigger counts as pre-trigger.
- R3: Playback sends min(4·(read count), samples stored, capacity) samples, in order from oldest to newest, ending with the last sample stored, and then the block returns to idle and sends nothing more.
- R4: `cfg_flags` bits 2, 3, 4 and 5, when 1, disable channel groups 0 (bits 7:0), 1, 2 and 3 (bits 31:24) respectively. Each sample is sent as one byte per enabled group, lowest group first. Other flag bits except the test bit have no effect.
- R5: With n enabled groups the buffer holds floor(4·DEPTH_ROWS/n) samples (1024, 512, 341 and 256 at the default depth). Older samples are overwritten once it is full.
- R6: While armed or counting post-trigger samples, a sample is taken in the first cycle after arming and then once every `divider`+1 clock cycles.
- R7: When `cfg_flags[11]` is 1, the byte stored for group g of the i-th sample since arming (counting from 0) is (i + 64·g) mod 256. When it is 0, the byte is `smp_in[8g+7:8g]`.
- R8: A `clear` pulse during capture or playback returns the block to idle: `tx_valid` is low from the next cycle, no further bytes are sent, and later triggers are ignored until the block is armed again.
- R9: An `arm` pulse with all four groups disabled is ignored, and no bytes are ever sent for it.
- R10: After reset `tx_valid` is low. While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start pulse; latches configuration and begins storing |
| clear | input | 1 | Abort pulse; returns to idle |
| trig | input | 1 | Trigger-start pulse |
| size_arg | input | 2*CNT_W | Capture-size argument: read count minus one (low half), delay count minus one (high half) |
| cfg_flags | input | 16 | Flag word: group disables at bits 5:2, internal test pattern at bit 11 |
| divider | input | DIV_W | Sample period minus one, in clock cycles |
| smp_in | input | 32 | Input channels 31:0 |
| tx_data | output | 8 | Playback byte |
| tx_valid | output | 1 | Playback byte is valid |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The bench runs full captures in test-pattern mode, so each played-back byte shows which sample and group it came from. An off-by-one in the post-trigger count, a swapped count field or a wrong divider shifts the final sample index, and the bench catches that shift. It targets the capacity limits with three groups, where capacity does not divide evenly, and with one group at the full 1024 samples. There, a wrong wrap limit or a wrong oldest-sample pointer garbles the sequence or shortens it. It also checks sparse group masks, where a packing error puts a byte in the wrong position. Aborts during playback and during capture are tested, since a design that ignores the clear keeps streaming bytes. An all-disabled arm is tested, where a design that accepts it would still send bytes.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int NGRP = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_POST,
    ST_RSETUP,
    ST_RFETCH,
    ST_RLOAD,
    ST_RSEND
  } cap_state_e;

  function automatic logic [2:0] pop4(input logic [3:0] v);
    return {2'b0, v[0]} + {2'b0, v[1]} + {2'b0, v[2]} + {2'b0, v[3]};
  endfunction
endpackage

// File: rtl/cap_pacer.sv
module cap_pacer #(
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             test_en,
  input  logic [31:0]      smp_in,
  output logic             strobe,
  output logic [31:0]      sample
);
  logic [DIV_W-1:0] div_cnt;
  logic [7:0]       idx;

  assign strobe = run && (div_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      div_cnt <= '0;
      idx     <= '0;
    end else if (run) begin
      if (div_cnt == '0) begin
        div_cnt <= div;
        idx     <= idx + 8'd1;
      end else begin
        div_cnt <= div_cnt - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_src
    assign sample[8*g +: 8] = test_en ? (idx + 8'(64 * g)) : smp_in[8*g +: 8];
  end
endmodule

// File: rtl/cap_packer.sv
module cap_packer (
  input  logic [3:0]  grp_en,
  input  logic [31:0] din,
  output logic [31:0] packed_out
);
  always_comb begin
    logic [2:0] k;
    packed_out = '0;
    k = '0;
    for (int g = 0; g < 4; g++) begin
      if (grp_en[g]) begin
        packed_out[{k[1:0], 3'b000} +: 8] = din[8*g +: 8];
        k = k + 3'd1;
      end
    end
  end
endmodule

// File: rtl/cap_lane_ram.sv
module cap_lane_ram #(
  parameter int ROWS = 256,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [RW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import cap_pkg::*;
#(
  parameter int DEPTH_ROWS = 256,
  parameter int CNT_W      = 16,
  parameter int DIV_W      = 24,
  parameter int TEST_BIT   = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm,
  input  logic               clear,
  input  logic               trig,
  input  logic [2*CNT_W-1:0] size_arg,
  input  logic [15:0]        cfg_flags,
  input  logic [DIV_W-1:0]   divider,
  input  logic [31:0]        smp_in,
  output logic [7:0]         tx_data,
  output logic               tx_valid,
  input  logic               tx_ready
);
  localparam int BYTES = NGRP * DEPTH_ROWS;
  localparam int PW    = $clog2(BYTES) + 1;
  localparam int SCW   = CNT_W + 3;
  localparam int RW    = $clog2(DEPTH_ROWS);

  function automatic logic [SCW-1:0] cap_of(input logic [2:0] n);
    case (n)
      3'd1:    return SCW'(BYTES);
      3'd2:    return SCW'(BYTES / 2);
      3'd3:    return SCW'(BYTES / 3);
      default: return SCW'(BYTES / 4);
    endcase
  endfunction

  function automatic logic [PW-1:0] lim_of(input logic [2:0] n);
    case (n)
      3'd1:    return PW'(BYTES);
      3'd2:    return PW'((BYTES / 2) * 2);
      3'd3:    return PW'((BYTES / 3) * 3);
      default: return PW'((BYTES / 4) * 4);
    endcase
  endfunction

  cap_state_e       state;
  logic [3:0]       grp_en_q;
  logic [2:0]       n_q;
  logic             test_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] rd_m1_q, dl_m1_q;
  logic [SCW-1:0]   cap_q, stored, post_cnt;
  logic [PW-1:0]    lim_q, wptr, rp, rem;
  logic [1:0]       lane_q;

  logic [3:0]  arm_en;
  logic [2:0]  arm_n;
  logic        start, run, strobe;
  logic [31:0] sample, packed_smp;
  logic [7:0]  lane_dout [NGRP];

  assign arm_en = ~cfg_flags[5:2];
  assign arm_n  = pop4(arm_en);
  assign start  = (state == ST_IDLE) && arm && !clear && (arm_n != 3'd0);
  assign run    = (state == ST_ARMED) || (state == ST_POST);

  cap_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk(clk), .rst(rst), .start(start), .run(run), .div(div_q),
    .test_en(test_q), .smp_in(smp_in), .strobe(strobe), .sample(sample)
  );

  cap_packer u_packer (.grp_en(grp_en_q), .din(sample), .packed_out(packed_smp));

  for (genvar j = 0; j < NGRP; j++) begin : g_lane
    logic [1:0]    k;
    logic [PW-1:0] a;
    logic          we;
    assign k  = 2'(j) - wptr[1:0];
    assign a  = wptr + PW'(k);
    assign we = strobe && ({1'b0, k} < n_q);
    cap_lane_ram #(.ROWS(DEPTH_ROWS)) u_ram (
      .clk(clk), .we(we), .waddr(a[RW+1:2]), .wdata(packed_smp[{k, 3'b000} +: 8]),
      .raddr(rp[RW+1:2]), .rdata(lane_dout[j])
    );
  end

  logic [SCW-1:0] rd_req, post_tgt, nread, rbytes_s;
  logic [PW-1:0]  rbytes, wptr_add, wptr_nx, rp_add, rp_nx, rp_start;

  always_comb begin
    rd_req   = SCW'({rd_m1_q, 2'b00}) + SCW'(4);
    post_tgt = SCW'({dl_m1_q, 2'b00}) + SCW'(4);
    nread    = (rd_req < stored) ? rd_req : stored;
    rbytes_s = nread * SCW'(n_q);
    rbytes   = PW'(rbytes_s);
    wptr_add = wptr + PW'(n_q);
    wptr_nx  = (wptr_add == lim_q) ? '0 : wptr_add;
    rp_add   = rp + PW'(1);
    rp_nx    = (rp_add == lim_q) ? '0 : rp_add;
    rp_start = (wptr >= rbytes) ? (wptr - rbytes) : (wptr + lim_q - rbytes);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      grp_en_q <= '0;
      n_q      <= '0;
      test_q   <= 1'b0;
      div_q    <= '0;
      rd_m1_q  <= '0;
      dl_m1_q  <= '0;
      cap_q    <= '0;
      lim_q    <= '0;
      stored   <= '0;
      post_cnt <= '0;
      wptr     <= '0;
      rp       <= '0;
      rem      <= '0;
      lane_q   <= '0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else if (clear) begin
      state    <= ST_IDLE;
      tx_valid <= 1'b0;
    end else begin
      if (run && strobe) begin
        wptr   <= wptr_nx;
        stored <= (stored == cap_q) ? cap_q : stored + 1'b1;
      end
      case (state)
        ST_IDLE: if (start) begin
          grp_en_q <= arm_en;
          n_q      <= arm_n;
          test_q   <= cfg_flags[TEST_BIT];
          div_q    <= divider;
          rd_m1_q  <= size_arg[CNT_W-1:0];
          dl_m1_q  <= size_arg[2*CNT_W-1:CNT_W];
          cap_q    <= cap_of(arm_n);
          lim_q    <= lim_of(arm_n);
          wptr     <= '0;
          stored   <= '0;
          state    <= ST_ARMED;
        end
        ST_ARMED: if (trig) begin
          post_cnt <= '0;
          state    <= ST_POST;
        end
        ST_POST: if (strobe) begin
          post_cnt <= post_cnt + 1'b1;
          if (post_cnt + 1'b1 == post_tgt) state <= ST_RSETUP;
        end
        ST_RSETUP: begin
          rp    <= rp_start;
          rem   <= rbytes;
          state <= ST_RFETCH;
        end
        ST_RFETCH: begin
          lane_q <= rp[1:0];
          state  <= ST_RLOAD;
        end
        ST_RLOAD: begin
          tx_data  <= lane_dout[lane_q];
          tx_valid <= 1'b1;
          state    <= ST_RSEND;
        end
        ST_RSEND: if (tx_ready) begin
          tx_valid <= 1'b0;
          rp       <= rp_nx;
          rem      <= rem - 1'b1;
          state    <= (rem == PW'(1)) ? ST_IDLE : ST_RFETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/capture_ctrl_chk.sv
module capture_ctrl_chk
  import cap_pkg::*;
#(
  parameter int PW  = 11,
  parameter int SCW = 19
) (
  input logic           clk,
  input logic           rst,
  input logic           clear,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic [7:0]     tx_data,
  input cap_state_e     state,
  input logic [PW-1:0]  wptr,
  input logic [PW-1:0]  rp,
  input logic [PW-1:0]  lim_q,
  input logic [SCW-1:0] stored,
  input logic [SCW-1:0] cap_q
);
  // R10: an offered byte is held until it is accepted
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready && !clear |=> tx_valid && $stable(tx_data));

  // R8: clear drops the byte stream and returns to idle
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clear |=> !tx_valid && state == ST_IDLE);

  // R5: write pointer stays inside the packed region while storing
  assert_wptr_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED || state == ST_POST) |-> wptr < lim_q);

  // R5: stored sample count never exceeds the capacity
  assert_stored_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED || state == ST_POST) |-> stored <= cap_q);

  // R3: read pointer stays inside the packed region during playback
  assert_rp_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RFETCH || state == ST_RLOAD || state == ST_RSEND) |-> rp < lim_q);

  // R3: bytes are only offered in the send state
  assert_valid_R3: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> state == ST_RSEND);

  // R2: playback setup is only reached from the post-trigger phase
  assert_stop_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_RSETUP) |-> $past(state) == ST_POST);
endmodule

bind capture_ctrl capture_ctrl_chk #(.PW(PW), .SCW(SCW)) u_chk (
  .clk(clk), .rst(rst), .clear(clear), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .state(state), .wptr(wptr), .rp(rp), .lim_q(lim_q),
  .stored(stored), .cap_q(cap_q)
);

// File: tb/capture_ctrl_tb_top.sv
module capture_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst, arm, clear, trig, tx_ready, tx_valid;
  logic [31:0] size_arg, smp_in;
  logic [15:0] cfg_flags;
  logic [23:0] divider;
  logic [7:0]  tx_data;
  int          checks = 0;
  int          fails  = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  capture_ctrl dut_i (
    .clk(clk), .rst(rst), .arm(arm), .clear(clear), .trig(trig),
    .size_arg(size_arg), .cfg_flags(cfg_flags), .divider(divider),
    .smp_in(smp_in), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R5: capacity at the default depth of 256 rows per lane
  function automatic int cap_for(input int n);
    return 1024 / n;
  endfunction

  // R7: test pattern byte for sample i, group g; otherwise the input pins
  function automatic logic [7:0] exp_byte(input int i, input int g, input int tst,
                                          input logic [31:0] smp);
    if (tst != 0) return 8'((i + 64 * g) % 256);
    return smp[8*g +: 8];
  endfunction

  task automatic run_cap(input int r, input int d, input int off, input int tst,
                         input int dv, input int w, input logic [31:0] smp,
                         input string req, input int abort_after);
    int en_g[4];
    int n, npre, total, stored, nread, first, nbytes, target;
    int got, bad, hold_bad, cyc, extra, first_bad_a, first_bad_e;
    bit pv;
    logic [7:0] pd, e;
    n = 0;
    for (int g = 0; g < 4; g++) if (((off >> g) & 1) == 0) begin en_g[n] = g; n++; end
    // R6: samples at edges 1, 1+(dv+1), ... up to and including the trigger edge
    npre   = (w - 1) / (dv + 1) + 1;
    // R1, R2: post-trigger count is 4*(delay+1)
    total  = npre + 4 * (d + 1);
    stored = (n == 0) ? 0 : ((total < cap_for(n)) ? total : cap_for(n));
    // R3: read count limited by stored samples
    nread  = (4 * (r + 1) < stored) ? 4 * (r + 1) : stored;
    first  = total - nread;
    nbytes = nread * n;
    target = (abort_after >= 0) ? abort_after : nbytes;

    @(negedge clk);
    size_arg  = {16'(d), 16'(r)};
    // R4: bits 0 and 7 set as noise; they must have no effect
    cfg_flags = 16'(off << 2) | (tst != 0 ? 16'h0800 : 16'h0) | 16'h0081;
    divider   = 24'(dv);
    smp_in    = smp;
    arm       = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    repeat (w - 1) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;

    got = 0; bad = 0; hold_bad = 0; cyc = 0; pv = 0; pd = '0;
    first_bad_a = 0; first_bad_e = 0;
    while (got < target && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      if (pv && !(tx_valid && tx_data == pd)) hold_bad++;
      tx_ready = ($urandom % 10) < 7;
      if (tx_valid && tx_ready) begin
        e = exp_byte(first + got / n, en_g[got % n], tst, smp);
        if (tx_data !== e) begin
          if (bad == 0) begin first_bad_a = int'(tx_data); first_bad_e = int'(e); end
          bad++;
        end
        got++;
        pv = 0;
      end else if (tx_valid) begin
        pv = 1; pd = tx_data;
      end else begin
        pv = 0;
      end
    end

    if (abort_after >= 0) begin
      // R8: clear during playback stops the stream
      @(negedge clk);
      tx_ready = 1'b0;
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      tx_ready = 1'b1;
    end
    extra = 0;
    repeat (n == 0 || abort_after >= 0 ? 3000 : 40) begin
      @(negedge clk);
      tx_ready = 1'b1;
      if (tx_valid) extra++;
    end
    tx_ready = 1'b0;

    check(got == target, req, "byte count", got, target);
    check(bad == 0, req, "byte values (first mismatch)", first_bad_a, first_bad_e);
    check(hold_bad == 0, "R10", "held byte changed while not ready", hold_bad, 0);
    check(extra == 0, (abort_after >= 0) ? "R8" : "R3", "bytes after end", extra, 0);
  endtask

  initial begin
    #(64'd190000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int rr, dd, oo, dv, ww;
    void'($urandom(32'd4711));
    rst = 1'b1; arm = 1'b0; clear = 1'b0; trig = 1'b0; tx_ready = 1'b0;
    size_arg = '0; cfg_flags = '0; divider = '0; smp_in = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(tx_valid == 1'b0, "R10", "tx_valid after reset", int'(tx_valid), 0);

    // R3: read request larger than what was stored
    run_cap(3, 1, 4'b0000, 1, 0, 5, 32'h0, "R3", -1);
    // R4 R6: sparse groups (0 and 2) with divider 2
    run_cap(0, 2, 4'b1010, 1, 2, 10, 32'h0, "R4", -1);
    // R5: three groups, capacity 341, wrapped buffer
    run_cap(120, 100, 4'b0100, 1, 0, 300, 32'h0, "R5", -1);
    // R5: one group, full 1024-sample buffer
    run_cap(255, 255, 4'b1110, 1, 1, 3, 32'h0, "R5", -1);
    // R7: input pins instead of the pattern
    run_cap(1, 0, 4'b0000, 0, 0, 2, 32'hC35A961E, "R7", -1);
    // R9: all groups disabled, arm ignored
    run_cap(2, 1, 4'b1111, 1, 0, 4, 32'h0, "R9", -1);
    // R8: clear during playback after five bytes
    run_cap(10, 3, 4'b0000, 1, 0, 4, 32'h0, "R8", 5);

    // R8: clear during capture, later trigger ignored
    @(negedge clk);
    size_arg = {16'd0, 16'd0}; cfg_flags = 16'h0800; divider = '0; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    repeat (10) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    begin
      int seen = 0;
      repeat (500) begin
        @(negedge clk);
        tx_ready = 1'b1;
        if (tx_valid) seen++;
      end
      check(seen == 0, "R8", "bytes after clear in capture", seen, 0);
    end

    // R1 R2 R6: constrained random captures
    for (int t = 0; t < 8; t++) begin
      rr = $urandom % 61;
      dd = $urandom % 41;
      oo = $urandom % 15;
      dv = $urandom % 4;
      ww = 1 + $urandom % 400;
      run_cap(rr, dd, oo, 1, dv, ww, 32'h0, "R2", -1);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule